// File: doc/BRIEF.md
# Group-Counted Delayed Branch Controller

This block sits in the decode stage of a superscalar front end and decides when a resolved branch actually changes the fetch stream. Every branch carries a small delay field that tells how many whole instruction groups must finish issuing before control moves to the target. The controller captures the target when a taken branch resolves. It then counts group-issue completion pulses until the encoded number has been seen, and raises a one-cycle redirect with the captured target, together with a flush of anything fetched beyond the delay groups.

A branch that is not taken, or whose Boolean guard evaluated false, leaves the sequential fetch stream untouched and costs no cycle. Only one delayed branch may be outstanding. While one is pending, the block lowers its ready output and ignores any further branch presented to it, so upstream logic must hold that branch until ready returns.

Top module: `dly_branch_ctrl`

## Requirements
- R1: While and after reset, with no branch presented, `redirect` and `flush` are 0, `redirect_pc` is 0 and `br_ready` is 1.
- R2: A branch accepted (`br_valid` and `br_ready` both 1 at a clock edge) with `br_taken` = 0 never causes `redirect`, and `br_ready` stays 1.
- R3: A branch accepted with `br_taken` = 1 but `br_guard_ok` = 0 behaves exactly like a not-taken branch.
- R4: A taken branch accepted with `br_delay` = 0 drives `redirect` high in the cycle that directly follows the accepting edge.
- R5: A taken branch accepted with `br_delay` = d (1 to 3) drives `redirect` high in the cycle that follows the clock edge at which the d-th `grp_done` pulse is sampled. Only pulses sampled after the accepting edge are counted, and a gap without pulses extends the wait.
- R6: `redirect` lasts exactly one cycle. During that cycle `flush` is 1 and `redirect_pc` equals the target captured at acceptance. In every other cycle `flush` and `redirect_pc` are 0.
- R7: `br_ready` is 0 from the cycle after a taken branch is accepted through its redirect cycle inclusive. A branch presented while `br_ready` is 0 is ignored.
- R8: `grp_done` pulses while no branch is pending have no effect on any output or on the counting of a later branch.
- R9: Changes on `br_target` after acceptance do not alter the `redirect_pc` of the pending branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A branch is resolved this cycle |
| br_taken | input | 1 | Resolved branch direction |
| br_guard_ok | input | 1 | Branch guard condition evaluated true |
| br_target | input | ADDR_W | Branch target address |
| br_delay | input | DLY_W | Number of delay groups before transfer |
| grp_done | input | 1 | One instruction group finished issuing |
| br_ready | output | 1 | No branch pending; a new branch may be accepted |
| redirect | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | ADDR_W | Redirect address, 0 when not redirecting |
| flush | output | 1 | Discard instructions fetched past the delay groups |

## Verification
A wrong group count shows at the ports as a redirect that comes one or more group pulses early or late, visible in the first cycle where the bench expects the pulse. A stuck pending state shows as `br_ready` held low, or as a missing return to ready, within one cycle of the expected redirect. A corrupted target register appears directly on `redirect_pc` in the redirect cycle. A leak of the idle state into counting shows as a redirect on a branch that was not taken, or a branch accepted while one was pending.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FIRE = 2'd2
  } dbc_state_e;
endpackage

// File: rtl/dbc_grp_counter.sv
module dbc_grp_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             cnt_last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (dec)
      cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load || dec)
      cnt_q <= cnt_d;
  end

  assign cnt_last = (cnt_q == ONE);

  // R5: a group is never counted against an empty counter
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt_q != '0));
endmodule

// File: rtl/dbc_seq.sv
module dbc_seq
  import dbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept_taken,
  input  logic       delay_zero,
  input  logic       grp_done,
  input  logic       cnt_last,
  output dbc_state_e state,
  output logic       load_cnt,
  output logic       dec_cnt
);
  dbc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_taken) state_d = delay_zero ? ST_FIRE : ST_WAIT;
      ST_WAIT: if (grp_done && cnt_last) state_d = ST_FIRE;
      ST_FIRE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= ST_IDLE;
    else
      state_q <= state_d;
  end

  assign state    = state_q;
  assign load_cnt = (state_q == ST_IDLE) && accept_taken && !delay_zero;
  assign dec_cnt  = (state_q == ST_WAIT) && grp_done;

  // R7: the redirect state is left after exactly one cycle
  p_fire_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIRE) |=> (state_q == ST_IDLE));

  // R5: waiting only ends on a counted group
  p_wait_needs_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT) && !grp_done) |=> (state_q == ST_WAIT));
endmodule

// File: rtl/dly_branch_ctrl.sv
module dly_branch_ctrl
  import dbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DLY_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic              br_taken,
  input  logic              br_guard_ok,
  input  logic [ADDR_W-1:0] br_target,
  input  logic [DLY_W-1:0]  br_delay,
  input  logic              grp_done,
  output logic              br_ready,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic              flush
);
  localparam int CNT_W = DLY_W;

  dbc_state_e        state;
  logic              accept, taken_eff, accept_taken;
  logic              load_cnt, dec_cnt, cnt_last;
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  logic              tgt_en;

  assign accept       = br_valid && br_ready;
  assign taken_eff    = br_taken && br_guard_ok;
  assign accept_taken = accept && taken_eff;

  dbc_seq i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_taken (accept_taken),
    .delay_zero   (br_delay == '0),
    .grp_done     (grp_done),
    .cnt_last     (cnt_last),
    .state        (state),
    .load_cnt     (load_cnt),
    .dec_cnt      (dec_cnt)
  );

  dbc_grp_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_cnt),
    .load_val (br_delay),
    .dec      (dec_cnt),
    .cnt_last (cnt_last)
  );

  assign tgt_en = accept_taken;
  assign tgt_d  = br_target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tgt_q <= '0;
    else if (tgt_en)
      tgt_q <= tgt_d;
  end

  assign br_ready    = (state == ST_IDLE);
  assign redirect    = (state == ST_FIRE);
  assign flush       = redirect;
  assign redirect_pc = redirect ? tgt_q : '0;

  // R6: redirect is a single-cycle pulse
  p_redirect_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);

  // R2 / R3: a not-taken or guard-failed branch never redirects
  p_no_redirect_nt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_ready && !(br_taken && br_guard_ok)) |=> !redirect);

  // R4: zero delay redirects in the next cycle
  p_zero_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_ready && br_taken && br_guard_ok && (br_delay == '0)) |=> redirect);

  // R9: the captured target holds while a branch stays pending
  p_target_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_ready && $past(!br_ready)) |-> $stable(tgt_q));
endmodule

// File: tb/test_dly_branch_ctrl.sv
`timescale 1ns/1ps
module test_dly_branch_ctrl;
  localparam int ADDR_W = 32;
  localparam int DLY_W  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              br_valid = 1'b0, br_taken = 1'b0, br_guard_ok = 1'b1;
  logic [ADDR_W-1:0] br_target = '0;
  logic [DLY_W-1:0]  br_delay = '0;
  logic              grp_done = 1'b0;
  logic              br_ready, redirect, flush;
  logic [ADDR_W-1:0] redirect_pc;

  int    n_checks = 0;
  int    n_fails  = 0;
  int    cycles   = 0;
  string cur_req  = "R1";

  // reference model state
  int              m_state = 0;   // 0 idle, 1 waiting for groups, 2 redirecting
  int              m_cnt   = 0;
  logic [ADDR_W-1:0] m_tgt = '0;

  always #2 clk = ~clk;

  dly_branch_ctrl #(.ADDR_W(ADDR_W), .DLY_W(DLY_W)) i_dly_branch_ctrl (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
    .br_guard_ok(br_guard_ok), .br_target(br_target), .br_delay(br_delay),
    .grp_done(grp_done), .br_ready(br_ready), .redirect(redirect),
    .redirect_pc(redirect_pc), .flush(flush)
  );

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_state = 0;
      m_cnt   = 0;
    end else if (m_state == 0) begin
      if (br_valid && br_taken && br_guard_ok) begin
        m_tgt = br_target;
        if (br_delay == 0) m_state = 2;
        else begin
          m_state = 1;
          m_cnt   = int'(br_delay);
        end
      end
    end else if (m_state == 1) begin
      if (grp_done) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_state = 2;
      end
    end else begin
      m_state = 0;
    end
  end

  task automatic chk1(string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [ADDR_W-1:0] exp_pc;
    exp_pc = (m_state == 2) ? m_tgt : '0;
    chk1("redirect", redirect, m_state == 2);
    chk1("flush",    flush,    m_state == 2);
    chk1("br_ready", br_ready, m_state == 0);
    n_checks++;
    if (redirect_pc !== exp_pc) begin
      n_fails++;
      $display("FAIL %s redirect_pc: actual %h expected %h (t=%0t)", cur_req, redirect_pc, exp_pc, $time);
    end
    if (cycles > 50000) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  task automatic step(logic v, logic t, logic g, int d, logic [ADDR_W-1:0] tg, logic gd);
    br_valid    = v;
    br_taken    = t;
    br_guard_ok = g;
    br_delay    = DLY_W'(d);
    br_target   = tg;
    grp_done    = gd;
    @(negedge clk);
  endtask

  task automatic idle(int n, logic gd);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, 0, 32'hDEAD_0000, gd);
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3, 1'b0);

    cur_req = "R2";                       // not taken, then groups
    step(1'b1, 1'b0, 1'b1, 2, 32'h0000_1000, 1'b0);
    idle(4, 1'b1);

    cur_req = "R3";                       // taken but guard failed
    step(1'b1, 1'b1, 1'b0, 0, 32'h0000_2000, 1'b0);
    step(1'b1, 1'b1, 1'b0, 3, 32'h0000_2004, 1'b1);
    idle(4, 1'b1);

    cur_req = "R4";                       // zero delay
    step(1'b1, 1'b1, 1'b1, 0, 32'h0000_3000, 1'b0);
    idle(3, 1'b0);

    cur_req = "R5";                       // delays 1..3, pulse in accept cycle ignored
    for (int d = 1; d <= 3; d++) begin
      step(1'b1, 1'b1, 1'b1, d, 32'h0000_4000 + 32'(d), 1'b1);
      for (int k = 0; k < d; k++) begin
        idle(2, 1'b0);
        idle(1, 1'b1);
      end
      idle(3, 1'b0);
    end
    step(1'b1, 1'b1, 1'b1, 3, 32'h0000_4100, 1'b0);   // back-to-back groups
    idle(3, 1'b1);
    idle(3, 1'b0);

    cur_req = "R7";                       // second branch held off while busy
    step(1'b1, 1'b1, 1'b1, 2, 32'h0000_5000, 1'b0);
    step(1'b1, 1'b1, 1'b1, 0, 32'h0000_5555, 1'b1);
    step(1'b1, 1'b1, 1'b1, 0, 32'h0000_5555, 1'b0);
    step(1'b1, 1'b1, 1'b1, 0, 32'h0000_5555, 1'b1);
    step(1'b1, 1'b1, 1'b1, 0, 32'h0000_5555, 1'b0);   // redirect cycle, still ignored
    step(1'b1, 1'b1, 1'b1, 0, 32'h0000_6666, 1'b0);   // accepted now
    idle(3, 1'b0);

    cur_req = "R8";                       // idle pulses do not pre-count
    idle(5, 1'b1);
    step(1'b1, 1'b1, 1'b1, 2, 32'h0000_7000, 1'b0);
    idle(1, 1'b1);
    idle(2, 1'b0);
    idle(1, 1'b1);
    idle(3, 1'b0);

    cur_req = "R9";                       // target changes after acceptance
    step(1'b1, 1'b1, 1'b1, 1, 32'h0000_8000, 1'b0);
    step(1'b0, 1'b1, 1'b1, 0, 32'hFFFF_FFFF, 1'b0);
    step(1'b0, 1'b1, 1'b1, 0, 32'h1234_5678, 1'b1);
    idle(3, 1'b0);

    cur_req = "R6";                       // random traffic, full compare
    for (int i = 0; i < 400; i++)
      step(1'($urandom % 3 == 0), 1'($urandom), 1'($urandom % 4 != 0),
           int'($urandom % 4), 32'($urandom), 1'($urandom % 2));
    idle(6, 1'b0);

    cur_req = "R1";                       // reset in mid-flight
    step(1'b1, 1'b1, 1'b1, 3, 32'h0000_9000, 1'b0);
    rst_n = 1'b0;
    idle(3, 1'b1);
    rst_n = 1'b1;
    idle(4, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule